// File: doc/BRIEF.md
# Zero-Sequence Injection PWM Modulator

This block sits between a three-phase voltage reference generator and a carrier comparator in a three-level inverter controller. It accepts one sample of three signed phase references, where a magnitude of 1.0 stands for half the DC-bus voltage. The same sample carries a scalar modulation index and two harmonic samples, sin(3θ) and sin(9θ), taken from an external angle source. A mode code picks how a common offset is formed. That offset is added to every phase, and the block returns three saturated modulating signals with a valid strobe.

The offset can be zero (plain sinusoidal), centred between the largest and smallest references (space-vector style), chosen to pin one phase to a rail (discontinuous clamping), or built from the third harmonic, or from the third harmonic less a ninth-harmonic trim. Any of the non-zero offsets widens the linear range from 1.0 to 2/√3 of half the bus. All values are signed Q2.14: 16 bits, 14 fractional bits, so 1.0 is code 16384.

Top module: `zseq_pwm_mod`

## Requirements
- R1: While reset is held and directly after it is released, `out_valid` is 0 and all three outputs are 0.
- R2: A sample accepted on a rising edge with `in_valid` high produces exactly one `out_valid` pulse three rising edges later (counting the accepting edge as the first of three register stages). `mode_sel` is sampled only together with an accepted sample. While `out_valid` is low the outputs hold their last values.
- R3: Mode code 0 (sinusoidal) adds nothing: each output equals its own phase reference, subject to R10.
- R4: Mode code 1 (space-vector) adds floor(−(max+min)/2), where max and min are the largest and smallest of the three references.
- R5: Mode code 2 (discontinuous) adds 16384 − max when |max| ≥ |min|, so the largest phase lands exactly on +1.0. An exact tie of the two magnitudes takes this branch.
- R6: Mode code 2 adds −16384 − min when |max| < |min|, so the smallest phase lands exactly on −1.0. The magnitudes are formed one bit wider than the inputs, so a reference of −32768 compares correctly.
- R7: Mode code 3 (third harmonic) adds floor(m·w/2^14) with w = floor(sin3·2365/2^14). The constant 2365 is √3/12 in Q2.14.
- R8: Mode code 4 (third plus ninth harmonic) adds floor(m·w/2^14) with w = floor((sin3·3547 − sin9·355)/2^14). The constants 3547 and 355 are √3/8 and √3/80 in Q2.14.
- R9: A single offset value is added to all three phases of a sample.
- R10: Each output is reference plus offset, clamped to the range −16384 to +16384. An out-of-range sum never wraps.
- R11: The unused mode codes 5, 6 and 7 add nothing, exactly as code 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| mode_sel | input | 3 | Offset scheme: 0 sine, 1 space-vector, 2 discontinuous, 3 third harmonic, 4 third plus ninth harmonic, 5–7 treated as 0 |
| ref_a | input | 16 | Phase A reference, signed Q2.14 |
| ref_b | input | 16 | Phase B reference, signed Q2.14 |
| ref_c | input | 16 | Phase C reference, signed Q2.14 |
| mod_index | input | 16 | Modulation index m, signed Q2.14 |
| sin3 | input | 16 | sin(3θ) sample, signed Q2.14 |
| sin9 | input | 16 | sin(9θ) sample, signed Q2.14 |
| out_valid | output | 1 | Output sample strobe |
| out_a | output | 16 | Phase A modulating signal, signed Q2.14 |
| out_b | output | 16 | Phase B modulating signal, signed Q2.14 |
| out_c | output | 16 | Phase C modulating signal, signed Q2.14 |

## Verification
The bench uses the default 16-bit word with 14 fractional bits, so the full Q2.14 input span is reachable. This includes the code −32768 that tests the widened magnitude compare, references near ±2.0 that force clamping on both rails, and harmonic products that exercise the floor rounding. Back-to-back samples with rotating mode codes check that each mode travels with its own sample, and a mode change made while `in_valid` is low is shown to leave the held outputs untouched. A long run of random samples over every mode code, including the unused ones, is compared against an integer model of the offset rules.

// File: rtl/zseq_pkg.sv
package zseq_pkg;

    typedef enum logic [2:0] {
        ZS_SINE  = 3'd0,
        ZS_SPACE = 3'd1,
        ZS_CLAMP = 3'd2,
        ZS_H3    = 3'd3,
        ZS_H39   = 3'd4
    } zs_mode_e;

    localparam real ZS_ROOT3 = 1.7320508075688772;

endpackage

// File: rtl/zseq_extrema.sv
module zseq_extrema #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] ph_a,
    input  logic signed [W-1:0] ph_b,
    input  logic signed [W-1:0] ph_c,
    output logic signed [W-1:0] hi,
    output logic signed [W-1:0] lo,
    output logic                hi_dominant
);

    logic signed [W-1:0] hi_ab;
    logic signed [W-1:0] lo_ab;
    logic signed [W:0]   hi_x;
    logic signed [W:0]   lo_x;
    logic signed [W:0]   hi_mag;
    logic signed [W:0]   lo_mag;

    always_comb begin
        hi_ab = (ph_a > ph_b) ? ph_a : ph_b;
        lo_ab = (ph_a < ph_b) ? ph_a : ph_b;
        hi    = (hi_ab > ph_c) ? hi_ab : ph_c;
        lo    = (lo_ab < ph_c) ? lo_ab : ph_c;
    end

    // one guard bit keeps the magnitude of the most negative code positive
    always_comb begin
        hi_x        = {hi[W-1], hi};
        lo_x        = {lo[W-1], lo};
        hi_mag      = hi_x[W] ? -hi_x : hi_x;
        lo_mag      = lo_x[W] ? -lo_x : lo_x;
        hi_dominant = (hi_mag >= lo_mag);
    end

endmodule

// File: rtl/zseq_harmonic.sv
module zseq_harmonic
    import zseq_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int K3A  = 2365,
    parameter int K3B  = 3547,
    parameter int K9B  = 355
) (
    input  logic [2:0]          mode,
    input  logic signed [W-1:0] s3,
    input  logic signed [W-1:0] s9,
    output logic signed [W:0]   weight
);

    localparam int PW = 2 * W + 1;

    logic signed [PW-1:0] c3;
    logic signed [PW-1:0] c9;
    logic signed [PW-1:0] s3_x;
    logic signed [PW-1:0] s9_x;
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] acc_sh;

    always_comb begin
        case (mode)
            ZS_H3: begin
                c3 = PW'(K3A);
                c9 = '0;
            end
            ZS_H39: begin
                c3 = PW'(K3B);
                c9 = PW'(K9B);
            end
            default: begin
                c3 = '0;
                c9 = '0;
            end
        endcase
    end

    always_comb begin
        s3_x   = {{(W+1){s3[W-1]}}, s3};
        s9_x   = {{(W+1){s9[W-1]}}, s9};
        acc    = (s3_x * c3) - (s9_x * c9);
        acc_sh = acc >>> FRAC;
        weight = acc_sh[W:0];
    end

endmodule

// File: rtl/zseq_sat.sv
module zseq_sat #(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic signed [W-1:0] base,
    input  logic signed [W+1:0] inj,
    output logic signed [W-1:0] y
);

    localparam int SW = W + 3;
    localparam logic signed [SW-1:0] POS = SW'(1 << FRAC);
    localparam logic signed [SW-1:0] NEG = -POS;

    logic signed [SW-1:0] sum;

    always_comb begin
        sum = {{3{base[W-1]}}, base} + {inj[W+1], inj};
        if (sum > POS) begin
            y = POS[W-1:0];
        end else if (sum < NEG) begin
            y = NEG[W-1:0];
        end else begin
            y = sum[W-1:0];
        end
    end

endmodule

// File: rtl/zseq_pwm_mod.sv
module zseq_pwm_mod
    import zseq_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          mode_sel,
    input  logic signed [W-1:0] ref_a,
    input  logic signed [W-1:0] ref_b,
    input  logic signed [W-1:0] ref_c,
    input  logic signed [W-1:0] mod_index,
    input  logic signed [W-1:0] sin3,
    input  logic signed [W-1:0] sin9,
    output logic                out_valid,
    output logic signed [W-1:0] out_a,
    output logic signed [W-1:0] out_b,
    output logic signed [W-1:0] out_c
);

    localparam int NPH = 3;
    localparam int IW  = W + 2;
    localparam int PW  = 2 * W + 1;
    localparam real SCALE = 2.0 ** FRAC;
    localparam int K3A = int'(ZS_ROOT3 / 12.0 * SCALE);
    localparam int K3B = int'(ZS_ROOT3 / 8.0 * SCALE);
    localparam int K9B = int'(ZS_ROOT3 / 80.0 * SCALE);
    localparam logic signed [IW-1:0] ONE_I = IW'(1 << FRAC);

    // ---------------- stage A: sample capture ----------------
    logic                a_vld;
    logic [2:0]          a_mode;
    logic signed [W-1:0] a_ref [NPH];
    logic signed [W-1:0] a_m;
    logic signed [W-1:0] a_s3;
    logic signed [W-1:0] a_s9;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld  <= 1'b0;
            a_mode <= '0;
            a_m    <= '0;
            a_s3   <= '0;
            a_s9   <= '0;
            for (int i = 0; i < NPH; i++) begin
                a_ref[i] <= '0;
            end
        end else begin
            a_vld <= in_valid;
            if (in_valid) begin
                a_mode   <= mode_sel;
                a_m      <= mod_index;
                a_s3     <= sin3;
                a_s9     <= sin9;
                a_ref[0] <= ref_a;
                a_ref[1] <= ref_b;
                a_ref[2] <= ref_c;
            end
        end
    end

    // ---------------- stage B: extrema and harmonic weight ----------------
    logic signed [W-1:0]  ext_hi;
    logic signed [W-1:0]  ext_lo;
    logic                 ext_hi_dom;
    logic signed [W:0]    hw_c;
    logic signed [W:0]    span_sum;
    logic signed [IW-1:0] hi_i;
    logic signed [IW-1:0] lo_i;
    logic signed [IW-1:0] centre_c;
    logic signed [IW-1:0] rail_c;

    zseq_extrema #(
        .W (W)
    ) u_extrema (
        .ph_a        (a_ref[0]),
        .ph_b        (a_ref[1]),
        .ph_c        (a_ref[2]),
        .hi          (ext_hi),
        .lo          (ext_lo),
        .hi_dominant (ext_hi_dom)
    );

    zseq_harmonic #(
        .W    (W),
        .FRAC (FRAC),
        .K3A  (K3A),
        .K3B  (K3B),
        .K9B  (K9B)
    ) u_harmonic (
        .mode   (a_mode),
        .s3     (a_s3),
        .s9     (a_s9),
        .weight (hw_c)
    );

    always_comb begin
        span_sum = {ext_hi[W-1], ext_hi} + {ext_lo[W-1], ext_lo};
        centre_c = (-$signed({span_sum[W], span_sum})) >>> 1;
        hi_i     = {{2{ext_hi[W-1]}}, ext_hi};
        lo_i     = {{2{ext_lo[W-1]}}, ext_lo};
        rail_c   = ext_hi_dom ? (ONE_I - hi_i) : (-ONE_I - lo_i);
    end

    logic                 b_vld;
    logic [2:0]           b_mode;
    logic signed [W-1:0]  b_ref [NPH];
    logic signed [W-1:0]  b_m;
    logic signed [W:0]    b_w;
    logic signed [IW-1:0] b_centre;
    logic signed [IW-1:0] b_rail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_vld    <= 1'b0;
            b_mode   <= '0;
            b_m      <= '0;
            b_w      <= '0;
            b_centre <= '0;
            b_rail   <= '0;
            for (int i = 0; i < NPH; i++) begin
                b_ref[i] <= '0;
            end
        end else begin
            b_vld <= a_vld;
            if (a_vld) begin
                b_mode   <= a_mode;
                b_m      <= a_m;
                b_w      <= hw_c;
                b_centre <= centre_c;
                b_rail   <= rail_c;
                for (int i = 0; i < NPH; i++) begin
                    b_ref[i] <= a_ref[i];
                end
            end
        end
    end

    // ---------------- stage C: offset select, add, clamp ----------------
    logic signed [PW-1:0] m_x;
    logic signed [PW-1:0] w_x;
    logic signed [PW-1:0] hprod;
    logic signed [PW-1:0] hprod_sh;
    logic signed [IW-1:0] harm_inj;
    logic signed [IW-1:0] inj_c;
    logic signed [W-1:0]  sat_y [NPH];

    always_comb begin
        m_x      = {{(W+1){b_m[W-1]}}, b_m};
        w_x      = {{W{b_w[W]}}, b_w};
        hprod    = m_x * w_x;
        hprod_sh = hprod >>> FRAC;
        harm_inj = hprod_sh[IW-1:0];
    end

    always_comb begin
        unique case (b_mode)
            ZS_SPACE: inj_c = b_centre;
            ZS_CLAMP: inj_c = b_rail;
            ZS_H3:    inj_c = harm_inj;
            ZS_H39:   inj_c = harm_inj;
            default:  inj_c = '0;
        endcase
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        zseq_sat #(
            .W    (W),
            .FRAC (FRAC)
        ) u_sat (
            .base (b_ref[g]),
            .inj  (inj_c),
            .y    (sat_y[g])
        );
    end

    logic signed [W-1:0] o_ph [NPH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int i = 0; i < NPH; i++) begin
                o_ph[i] <= '0;
            end
        end else begin
            out_valid <= b_vld;
            if (b_vld) begin
                for (int i = 0; i < NPH; i++) begin
                    o_ph[i] <= sat_y[i];
                end
            end
        end
    end

    assign out_a = o_ph[0];
    assign out_b = o_ph[1];
    assign out_c = o_ph[2];

endmodule

// File: rtl/zseq_checker.sv
module zseq_checker #(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          mode_sel,
    input logic signed [W-1:0] ref_a,
    input logic signed [W-1:0] ref_b,
    input logic signed [W-1:0] ref_c,
    input logic                out_valid,
    input logic signed [W-1:0] out_a,
    input logic signed [W-1:0] out_b,
    input logic signed [W-1:0] out_c
);

    localparam logic signed [W-1:0] ONE_W = W'(1 << FRAC);
    localparam logic signed [W-1:0] NEG_W = -ONE_W;

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    function automatic logic signed [W+1:0] dif(logic signed [W-1:0] o, logic signed [W-1:0] r);
        return {{2{o[W-1]}}, o} - {{2{r[W-1]}}, r};
    endfunction

    function automatic logic inside_rails(logic signed [W-1:0] v);
        return (v > NEG_W) && (v < ONE_W);
    endfunction

    function automatic logic within_rails(logic signed [W-1:0] v);
        return (v >= NEG_W) && (v <= ONE_W);
    endfunction

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (within_rails(out_a) && within_rails(out_b) && within_rails(out_c))); // R10

    AST_SINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && ($past(mode_sel, 3) == 3'd0) && within_rails($past(ref_a, 3)))
        |-> (out_a == $past(ref_a, 3))); // R3

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && ($past(mode_sel, 3) >= 3'd5) && within_rails($past(ref_b, 3)))
        |-> (out_b == $past(ref_b, 3))); // R11

    AST_RAIL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && ($past(mode_sel, 3) == 3'd2))
        |-> ((out_a == ONE_W) || (out_b == ONE_W) || (out_c == ONE_W) ||
             (out_a == NEG_W) || (out_b == NEG_W) || (out_c == NEG_W))); // R5

    AST_COMMON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && inside_rails(out_a) && inside_rails(out_b) && inside_rails(out_c))
        |-> ((dif(out_a, $past(ref_a, 3)) == dif(out_b, $past(ref_b, 3))) &&
             (dif(out_b, $past(ref_b, 3)) == dif(out_c, $past(ref_c, 3))))); // R9

endmodule

bind zseq_pwm_mod zseq_checker #(
    .W    (W),
    .FRAC (FRAC)
) u_zseq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_sel  (mode_sel),
    .ref_a     (ref_a),
    .ref_b     (ref_b),
    .ref_c     (ref_c),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_c     (out_c)
);

// File: tb/test_zseq_pwm_mod.sv
`timescale 1ns/1ps
module test_zseq_pwm_mod;

    localparam int ONE = 16384;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        mode_sel = '0;
    logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic signed [15:0] mod_index = '0, sin3 = '0, sin9 = '0;
    logic              out_valid;
    logic signed [15:0] out_a, out_b, out_c;

    zseq_pwm_mod i_zseq_pwm_mod (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .mod_index(mod_index), .sin3(sin3), .sin9(sin9),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    a;
        int    b;
        int    c;
        int    due;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   last_a = 0, last_b = 0, last_c = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampq(int v);
        if (v > ONE) return ONE;
        if (v < -ONE) return -ONE;
        return v;
    endfunction

    function automatic int offset(int mode, int ra, int rb, int rc, int m, int s3, int s9);
        int mx, mn, w;
        mx = (ra > rb) ? ra : rb; mx = (mx > rc) ? mx : rc;
        mn = (ra < rb) ? ra : rb; mn = (mn < rc) ? mn : rc;
        case (mode)
            1: return (-(mx + mn)) >>> 1;
            2: begin
                if (((mx < 0) ? -mx : mx) >= ((mn < 0) ? -mn : mn)) return ONE - mx;
                return -ONE - mn;
            end
            3: begin
                w = (s3 * 2365) >>> 14;
                return (m * w) >>> 14;
            end
            4: begin
                w = (s3 * 3547 - s9 * 355) >>> 14;
                return (m * w) >>> 14;
            end
            default: return 0;
        endcase
    endfunction

    task automatic send(int mode, int ra, int rb, int rc, int m, int s3, int s9, string req);
        exp_t e;
        int   z;
        @(negedge clk);
        in_valid  = 1'b1;
        mode_sel  = mode[2:0];
        ref_a     = ra[15:0];
        ref_b     = rb[15:0];
        ref_c     = rc[15:0];
        mod_index = m[15:0];
        sin3      = s3[15:0];
        sin9      = s9[15:0];
        z = offset(mode, ra, rb, rc, m, s3, s9);
        e.a = clampq(ra + z);
        e.b = clampq(rb + z);
        e.c = clampq(rc + z);
        e.due = cyc + 3;
        e.req = req;
        sbq.push_back(e);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int rnd(int lo, int hi);
        return int'($urandom_range(hi - lo, 0)) + lo;
    endfunction

    // monitor: pops the scoreboard whenever the design presents a result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                chk("R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R2", "latency", cyc, e.due);
                chk(e.req, "out_a", int'(out_a), e.a);
                chk(e.req, "out_b", int'(out_b), e.b);
                chk(e.req, "out_c", int'(out_c), e.c);
                last_a = e.a;
                last_b = e.b;
                last_c = e.c;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_a after reset", int'(out_a), 0);
        chk("R1", "out_c after reset", int'(out_c), 0);

        // R3 plain pass-through, and R10 clamp on an overrange reference
        send(0, 8192, -4096, -4096, 0, 0, 0, "R3");
        send(0, 20000, -20000, 1234, 0, 0, 0, "R10");
        // R4 centred offset, with an odd sum to check the floor
        send(1, 14000, -3000, -11000, 0, 0, 0, "R4");
        send(1, 15000, 0, -7001, 0, 0, 0, "R4");
        send(1, 30000, -5000, -5000, 0, 0, 0, "R10");
        // R5 positive rail, including the exact tie
        send(2, 10000, -2000, -8000, 0, 0, 0, "R5");
        send(2, 6000, 0, -6000, 0, 0, 0, "R5");
        // R6 negative rail, including the most negative code
        send(2, 5000, 3000, -12000, 0, 0, 0, "R6");
        send(2, 100, 0, -32768, 0, 0, 0, "R6");
        // R7 third harmonic
        send(3, 8000, -4000, -4000, ONE, ONE, 0, "R7");
        send(3, 8000, -4000, -4000, ONE, -ONE, 0, "R7");
        send(3, -9000, 2000, 7000, 18919, 11585, 0, "R7");
        // R8 third plus ninth harmonic
        send(4, 8000, -4000, -4000, ONE, ONE, -ONE, "R8");
        send(4, 12000, -3000, -9000, 18919, -7000, 9000, "R8");
        // R11 unused codes
        send(5, 9000, -100, -8900, ONE, ONE, ONE, "R11");
        send(6, -3000, 3000, 0, ONE, ONE, ONE, "R11");
        send(7, 40, -40, 0, ONE, ONE, ONE, "R11");
        // R9 common offset on asymmetric references
        send(1, 3000, 1000, -500, 0, 0, 0, "R9");
        idle(6);

        // R2: mode and data changed with in_valid low must not reach the outputs
        send(0, 7000, -7000, 0, 0, 0, 0, "R2");
        @(negedge clk);
        in_valid  = 1'b0;
        mode_sel  = 3'd2;
        ref_a     = 16'sd100;
        ref_b     = 16'sd200;
        ref_c     = -16'sd300;
        idle(6);
        chk("R2", "held out_valid", int'(out_valid), 0);
        chk("R2", "held out_a", int'(out_a), last_a);
        chk("R2", "held out_b", int'(out_b), last_b);
        send(0, 500, 600, -700, 0, 0, 0, "R2");
        idle(6);

        // mixed random samples across every mode code
        for (int k = 0; k < 400; k++) begin
            send(rnd(0, 7), rnd(-32768, 32767), rnd(-32768, 32767), rnd(-32768, 32767),
                 rnd(0, 18919), rnd(-ONE, ONE), rnd(-ONE, ONE), "R9");
            if ((k % 37) == 5) idle(2);
        end
        idle(8);
        chk("R2", "scoreboard drained", sbq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule